// File: doc/BRIEF.md
# USB PHY Control Register Bank

A bank of 32-bit control and status words for a USB transceiver, reached over a plain word-oriented register bus with a write strobe, a read strobe, a byte address inside a 4 KB window, write data and registered read data. Nine registers sit in 16-byte groups. Each of the six read/write registers can be written at its base word, or changed bit by bit through three alias words that OR, AND-NOT or XOR the write data into the stored value. Software can therefore change single bits with one bus write and no read-modify-write.

Bit 31 of the control register is a soft-reset request. When it is requested, the power-down, transmit, receive and control registers reload their defaults. The status and debug words and the read-only words keep their values. A toggle write requests the reset only if the bit ends up at 1. Reads are registered and return data one cycle after the request. Unmapped words read as zero, and writes to them are dropped.

Top module: `phy_csr_bank`

## Requirements
- R1: After hardware reset the registers read: power-down 0x001E1C00, transmit 0x10060607, receive 0x00000000, control 0xC0200000, status 0x00000000, debug 0x7F180000, debug0-status 0x00000000, debug1 0x00001000, version 0x04020000.
- R2: Register g (power-down 0, transmit 1, receive 2, control 3, status 4, debug 5, debug0-status 6, debug1 7, version 8) has its base word at byte offset 16*g. Address bits [3:2] select the access kind: 0 base, 1 set, 2 clear, 3 toggle. A base write replaces the whole register.
- R3: For power-down, transmit, receive, control, debug and debug1, a set write ORs the data in, a clear write ANDs the register with the inverted data, and a toggle write XORs the data in.
- R4: A read of a set, clear or toggle word returns the current value of its base register.
- R5: Status is writable only at its base word (0x40). Writes to offsets 0x44 to 0x4C are ignored, and those words read zero.
- R6: A base or set write to control with data bit 31 set first applies the write. The power-down, transmit, receive and control registers then load their defaults from R1. All other registers are unchanged.
- R7: A toggle write to control with data bit 31 set causes the soft reset of R6 only if control bit 31 is 1 after the toggle. Otherwise it behaves as a plain toggle.
- R8: A clear write to control never causes a soft reset, and neither does any control write whose data bit 31 is 0.
- R9: Writes to version, debug0-status, the unused words of their groups, and any offset from 0x90 upward change no register.
- R10: Read data appears on rdata at the first clock edge after the cycle in which rd_en is high and holds until the next read. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 12 | Byte offset in the window; bits [1:0] are ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
On every cycle the assertions check the set/clear/toggle arithmetic on the debug register, the soft-reset result after control base, set and toggle writes, the absence of a soft reset on clear writes, the freezing of all storage on writes that miss, and zero read data for unmapped reads. The bench scenarios cover the full reset image, the alias read-back, the status alias words, the one-cycle read latency and the ordering of write-then-reset. They also confirm that the soft reset leaves status and the debug words alone. These need chains of bus operations that no single-cycle property can express.

// File: rtl/phy_csr_pkg.sv
package phy_csr_pkg;

  localparam int DW       = 32;
  localparam int NUM_REGS = 9;
  localparam int SRST_BIT = 31;

  localparam int IDX_PWR  = 0;
  localparam int IDX_TX   = 1;
  localparam int IDX_RX   = 2;
  localparam int IDX_CTRL = 3;
  localparam int IDX_STAT = 4;
  localparam int IDX_DBG  = 5;
  localparam int IDX_DBG0 = 6;
  localparam int IDX_DBG1 = 7;
  localparam int IDX_VER  = 8;

  typedef enum logic [1:0] {
    OP_BASE = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_TOG  = 2'd3
  } alias_op_e;

  typedef enum logic [1:0] {
    K_ALIASED  = 2'd0,
    K_BASEONLY = 2'd1,
    K_RDONLY   = 2'd2
  } reg_kind_e;

  // How each slot may be written.
  function automatic reg_kind_e kind_of(input int idx);
    case (idx)
      IDX_PWR, IDX_TX, IDX_RX, IDX_CTRL, IDX_DBG, IDX_DBG1: kind_of = K_ALIASED;
      IDX_STAT:                                             kind_of = K_BASEONLY;
      default:                                              kind_of = K_RDONLY;
    endcase
  endfunction

  // Hardware reset image; the soft-reset members reuse the same values.
  function automatic logic [DW-1:0] hw_default(input int idx);
    case (idx)
      IDX_PWR:  hw_default = 32'h001E_1C00;
      IDX_TX:   hw_default = 32'h1006_0607;
      IDX_RX:   hw_default = 32'h0000_0000;
      IDX_CTRL: hw_default = 32'hC020_0000;
      IDX_STAT: hw_default = 32'h0000_0000;
      IDX_DBG:  hw_default = 32'h7F18_0000;
      IDX_DBG0: hw_default = 32'h0000_0000;
      IDX_DBG1: hw_default = 32'h0000_1000;
      IDX_VER:  hw_default = 32'h0402_0000;
      default:  hw_default = '0;
    endcase
  endfunction

  function automatic logic soft_member(input int idx);
    soft_member = (idx == IDX_PWR) || (idx == IDX_TX) ||
                  (idx == IDX_RX)  || (idx == IDX_CTRL);
  endfunction

  // Bit arithmetic of one write through a given alias.
  function automatic logic [DW-1:0] apply_op(input logic [DW-1:0] cur,
                                             input logic [DW-1:0] wd,
                                             input alias_op_e     op);
    case (op)
      OP_SET:  apply_op = cur | wd;
      OP_CLR:  apply_op = cur & ~wd;
      OP_TOG:  apply_op = cur ^ wd;
      default: apply_op = wd;
    endcase
  endfunction

  // Soft-reset rule for a write that reaches control.
  function automatic logic srst_trigger(input alias_op_e     op,
                                        input logic [DW-1:0] wd,
                                        input logic [DW-1:0] ctrl_after);
    case (op)
      OP_BASE, OP_SET: srst_trigger = wd[SRST_BIT];
      OP_TOG:          srst_trigger = wd[SRST_BIT] && ctrl_after[SRST_BIT];
      default:         srst_trigger = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/phy_csr_decode.sv
module phy_csr_decode
  import phy_csr_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int GRP_W = ADDR_W - 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [GRP_W-1:0]  grp,
  output alias_op_e         op,
  output logic              rd_hit,
  output logic              wr_hit
);

  logic      in_range;
  reg_kind_e kind;
  logic      unused_lsb;

  assign unused_lsb = ^addr[1:0];
  assign grp        = addr[ADDR_W-1:4];
  assign op         = alias_op_e'(addr[3:2]);
  assign in_range   = (int'(grp) < NUM_REGS);
  assign kind       = kind_of(int'(grp));

  always_comb begin
    rd_hit = 1'b0;
    wr_hit = 1'b0;
    if (in_range) begin
      case (kind)
        K_ALIASED: begin
          rd_hit = 1'b1;
          wr_hit = 1'b1;
        end
        K_BASEONLY: begin
          rd_hit = (op == OP_BASE);
          wr_hit = (op == OP_BASE);
        end
        default: begin
          rd_hit = (op == OP_BASE);
          wr_hit = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/phy_csr_regfile.sv
module phy_csr_regfile
  import phy_csr_pkg::*;
#(
  parameter int GRP_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          wr_hit,
  input  logic [GRP_W-1:0]              grp,
  input  alias_op_e                     op,
  input  logic [DW-1:0]                 wdata,
  output logic [NUM_REGS-1:0][DW-1:0]   regs_q,
  output logic                          soft_rst_evt
);

  logic [NUM_REGS-1:0][DW-1:0] written;
  logic                        wr_ok;

  assign wr_ok = wr_en && wr_hit;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    logic sel;
    assign sel        = wr_ok && (int'(grp) == i);
    assign written[i] = sel ? apply_op(regs_q[i], wdata, op) : regs_q[i];

    if (soft_member(i)) begin : g_soft
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            regs_q[i] <= hw_default(i);
        else if (soft_rst_evt) regs_q[i] <= hw_default(i);
        else                   regs_q[i] <= written[i];
      end
    end else if (kind_of(i) == K_RDONLY) begin : g_ro
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q[i] <= hw_default(i);
        else        regs_q[i] <= regs_q[i];
      end
    end else begin : g_keep
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q[i] <= hw_default(i);
        else        regs_q[i] <= written[i];
      end
    end
  end

  assign soft_rst_evt = wr_ok && (int'(grp) == IDX_CTRL) &&
                        srst_trigger(op, wdata, written[IDX_CTRL]);

endmodule

// File: rtl/phy_csr_rdport.sv
module phy_csr_rdport
  import phy_csr_pkg::*;
#(
  parameter int GRP_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_en,
  input  logic                        rd_hit,
  input  logic [GRP_W-1:0]            grp,
  input  logic [NUM_REGS-1:0][DW-1:0] regs_q,
  output logic [DW-1:0]               rdata
);

  logic [DW-1:0] sel_word;

  always_comb begin
    sel_word = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_hit && (int'(grp) == i)) sel_word = regs_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= sel_word;
  end

endmodule

// File: rtl/phy_csr_bank.sv
module phy_csr_bank
  import phy_csr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata
);

  localparam int GRP_W = ADDR_W - 4;

  logic [GRP_W-1:0]            dec_grp;
  alias_op_e                   dec_op;
  logic                        rd_hit;
  logic                        wr_hit;
  logic [NUM_REGS-1:0][DW-1:0] regs_q;
  logic                        soft_rst_evt;

  phy_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (addr),
    .grp    (dec_grp),
    .op     (dec_op),
    .rd_hit (rd_hit),
    .wr_hit (wr_hit)
  );

  phy_csr_regfile #(.GRP_W(GRP_W)) u_rf (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_hit       (wr_hit),
    .grp          (dec_grp),
    .op           (dec_op),
    .wdata        (wdata),
    .regs_q       (regs_q),
    .soft_rst_evt (soft_rst_evt)
  );

  phy_csr_rdport #(.GRP_W(GRP_W)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (rd_en),
    .rd_hit (rd_hit),
    .grp    (dec_grp),
    .regs_q (regs_q),
    .rdata  (rdata)
  );

endmodule

// File: rtl/phy_csr_chk.sv
module phy_csr_chk
  import phy_csr_pkg::*;
#(
  parameter int GRP_W = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en,
  input logic                        rd_en,
  input logic [DW-1:0]               wdata,
  input logic [DW-1:0]               rdata,
  input logic [GRP_W-1:0]            dec_grp,
  input alias_op_e                   dec_op,
  input logic                        rd_hit,
  input logic                        wr_hit,
  input logic [NUM_REGS-1:0][DW-1:0] regs_q
);

  logic wr_dbg, wr_ctrl;
  assign wr_dbg  = wr_en && wr_hit && (int'(dec_grp) == IDX_DBG);
  assign wr_ctrl = wr_en && wr_hit && (int'(dec_grp) == IDX_CTRL);

  a_r3_set_or: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dbg && dec_op == OP_SET |=> regs_q[IDX_DBG] == ($past(regs_q[IDX_DBG]) | $past(wdata)));

  a_r3_clr_andnot: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dbg && dec_op == OP_CLR |=> regs_q[IDX_DBG] == ($past(regs_q[IDX_DBG]) & ~$past(wdata)));

  a_r3_tog_xor: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dbg && dec_op == OP_TOG |=> regs_q[IDX_DBG] == ($past(regs_q[IDX_DBG]) ^ $past(wdata)));

  a_r6_base_set_srst: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && (dec_op == OP_BASE || dec_op == OP_SET) && wdata[SRST_BIT]
    |=> regs_q[IDX_CTRL] == 32'hC020_0000 && regs_q[IDX_TX] == 32'h1006_0607
        && regs_q[IDX_PWR] == 32'h001E_1C00 && regs_q[IDX_RX] == 32'h0);

  a_r7_tog_clears_no_srst: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && dec_op == OP_TOG && wdata[SRST_BIT] && regs_q[IDX_CTRL][SRST_BIT]
    |=> !regs_q[IDX_CTRL][SRST_BIT] && $stable(regs_q[IDX_TX]));

  a_r7_tog_sets_srst: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && dec_op == OP_TOG && wdata[SRST_BIT] && !regs_q[IDX_CTRL][SRST_BIT]
    |=> regs_q[IDX_CTRL] == 32'hC020_0000 && regs_q[IDX_RX] == 32'h0);

  a_r8_clr_no_srst: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && dec_op == OP_CLR |=> $stable(regs_q[IDX_TX]) && $stable(regs_q[IDX_PWR]));

  a_r9_miss_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_hit |=> $stable(regs_q));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !rd_hit |=> rdata == '0);

  a_r4_alias_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_hit && (int'(dec_grp) == IDX_DBG) |=> rdata == $past(regs_q[IDX_DBG]));

endmodule

bind phy_csr_bank phy_csr_chk #(.GRP_W(GRP_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .wdata   (wdata),
  .rdata   (rdata),
  .dec_grp (dec_grp),
  .dec_op  (dec_op),
  .rd_hit  (rd_hit),
  .wr_hit  (wr_hit),
  .regs_q  (regs_q)
);

// File: tb/sim_phy_csr_bank.sv
module sim_phy_csr_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  phy_csr_bank u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic expect_rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_rd(a, v);
    chk(req, v, exp);
  endtask

  // R1 and R2: reset image at the group base offsets
  task automatic t_reset;
    expect_rd("R1 pwr",   12'h000, 32'h001E_1C00);
    expect_rd("R1 tx",    12'h010, 32'h1006_0607);
    expect_rd("R1 rx",    12'h020, 32'h0000_0000);
    expect_rd("R1 ctrl",  12'h030, 32'hC020_0000);
    expect_rd("R1 stat",  12'h040, 32'h0000_0000);
    expect_rd("R1 dbg",   12'h050, 32'h7F18_0000);
    expect_rd("R1 dbg0",  12'h060, 32'h0000_0000);
    expect_rd("R1 dbg1",  12'h070, 32'h0000_1000);
    expect_rd("R2 ver",   12'h080, 32'h0402_0000);
  endtask

  // R2 base replace, R3 set/clear/toggle arithmetic
  task automatic t_alias_ops;
    bus_wr(12'h010, 32'h1234_5678);
    expect_rd("R2 tx base write", 12'h010, 32'h1234_5678);
    bus_wr(12'h050, 32'h0000_FF00);
    bus_wr(12'h054, 32'h0000_00F0);
    expect_rd("R3 set",  12'h050, 32'h0000_FFF0);
    bus_wr(12'h058, 32'h0000_0F00);
    expect_rd("R3 clr",  12'h050, 32'h0000_F0F0);
    bus_wr(12'h05C, 32'h0000_FFFF);
    expect_rd("R3 tog",  12'h050, 32'h0000_0F0F);
    bus_wr(12'h02C, 32'h8000_0001);
    expect_rd("R3 rx tog", 12'h020, 32'h8000_0001);
  endtask

  // R4 alias words read the base value
  task automatic t_alias_read;
    expect_rd("R4 set word", 12'h054, 32'h0000_0F0F);
    expect_rd("R4 clr word", 12'h058, 32'h0000_0F0F);
    expect_rd("R4 tog word", 12'h05C, 32'h0000_0F0F);
  endtask

  // R5 status only at its base word
  task automatic t_status;
    bus_wr(12'h040, 32'hA5A5_A5A5);
    expect_rd("R5 base write", 12'h040, 32'hA5A5_A5A5);
    bus_wr(12'h044, 32'hFFFF_FFFF);
    bus_wr(12'h048, 32'hFFFF_FFFF);
    expect_rd("R5 alias write ignored", 12'h040, 32'hA5A5_A5A5);
    expect_rd("R5 alias reads zero", 12'h04C, 32'h0);
  endtask

  // R6 write then soft reset, via base and via set
  task automatic t_srst;
    bus_wr(12'h000, 32'hFFFF_FFFF);
    bus_wr(12'h010, 32'h0);
    bus_wr(12'h020, 32'h0000_FFFF);
    bus_wr(12'h070, 32'h0000_ABCD);
    bus_wr(12'h030, 32'h8000_0001);
    expect_rd("R6 pwr",  12'h000, 32'h001E_1C00);
    expect_rd("R6 tx",   12'h010, 32'h1006_0607);
    expect_rd("R6 rx",   12'h020, 32'h0);
    expect_rd("R6 ctrl", 12'h030, 32'hC020_0000);
    expect_rd("R6 dbg1 kept", 12'h070, 32'h0000_ABCD);
    expect_rd("R6 dbg kept",  12'h050, 32'h0000_0F0F);
    expect_rd("R6 stat kept", 12'h040, 32'hA5A5_A5A5);
    bus_wr(12'h020, 32'h0000_0042);
    bus_wr(12'h034, 32'h8000_0000);
    expect_rd("R6 set alias rx", 12'h020, 32'h0);
  endtask

  // R8 writes that must not reset
  task automatic t_no_srst;
    bus_wr(12'h020, 32'h0000_0077);
    bus_wr(12'h030, 32'h0000_0005);
    expect_rd("R8 ctrl plain", 12'h030, 32'h0000_0005);
    expect_rd("R8 rx kept",    12'h020, 32'h0000_0077);
    bus_wr(12'h038, 32'hFFFF_FFFF);
    expect_rd("R8 ctrl clr",   12'h030, 32'h0);
    expect_rd("R8 rx kept clr", 12'h020, 32'h0000_0077);
  endtask

  // R7 toggle rule
  task automatic t_tog;
    bus_wr(12'h03C, 32'h8000_0000);
    expect_rd("R7 tog to 1 ctrl", 12'h030, 32'hC020_0000);
    expect_rd("R7 tog to 1 rx",   12'h020, 32'h0);
    bus_wr(12'h020, 32'h0000_0055);
    bus_wr(12'h03C, 32'h8000_0000);
    expect_rd("R7 tog to 0 ctrl", 12'h030, 32'h4020_0000);
    expect_rd("R7 tog to 0 rx",   12'h020, 32'h0000_0055);
  endtask

  // R9 ignored writes
  task automatic t_ignored;
    bus_wr(12'h080, 32'hFFFF_FFFF);
    bus_wr(12'h060, 32'hFFFF_FFFF);
    bus_wr(12'h084, 32'hFFFF_FFFF);
    bus_wr(12'h090, 32'hFFFF_FFFF);
    bus_wr(12'hFFC, 32'hFFFF_FFFF);
    expect_rd("R9 ver",  12'h080, 32'h0402_0000);
    expect_rd("R9 dbg0", 12'h060, 32'h0);
    expect_rd("R9 rx untouched", 12'h020, 32'h0000_0055);
    expect_rd("R9 dbg1 untouched", 12'h070, 32'h0000_ABCD);
  endtask

  // R10 latency and unmapped reads
  task automatic t_latency;
    logic [31:0] v;
    bus_rd(12'h080, v);
    @(negedge clk);
    rd_en = 1'b1; addr = 12'h050;
    @(posedge clk);
    chk("R10 before edge", rdata, 32'h0402_0000);
    @(negedge clk);
    rd_en = 1'b0;
    chk("R10 after edge", rdata, 32'h0000_0F0F);
    repeat (3) @(negedge clk);
    chk("R10 holds", rdata, 32'h0000_0F0F);
    expect_rd("R10 unmapped", 12'hFF0, 32'h0);
    expect_rd("R10 unmapped 0x90", 12'h090, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 rdata at reset", rdata, 32'h0);
    rst_n = 1'b1;
    t_reset();
    t_alias_ops();
    t_alias_read();
    t_status();
    t_srst();
    t_no_srst();
    t_tog();
    t_ignored();
    t_latency();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule